// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small accumulator processor, built as a microprogrammed controller. A 7-bit microaddress register selects one line of a built-in control store each clock. Each line is an 18-bit microword that carries two microoperation codes for the datapath, a jump flag and a 7-bit target address. The two microoperation codes of the current line go straight out to the datapath, which is outside this block. The datapath returns the opcode and the condition field held in the instruction register, and the sign and zero state of the accumulator.

Every instruction starts with the same fetch lines at address 0. A dispatch line adds the opcode to the base of a sixteen-entry jump table. Each table entry jumps to that opcode's routine, and every routine ends with a jump back to address 0. Routines sit in fixed six-line slots, so opcode k starts at line 20 + 6k.

The conditional-skip routine tests the accumulator against the instruction's condition field. When the condition holds, it reaches the line that increments the program counter. When the condition fails, it falls through to a line that does nothing and then returns to fetch.

Top module: `useq_ctrl`

## Requirements
- R1: While reset is asserted, and from the moment it is asserted, uaddr is 0, uop1 is 1 and uop2 is 0. After reset is released, uaddr stays 0 for two more rising edges before it starts to advance.
- R2: A microword is 18 bits: uop1 in bits 17:13, uop2 in bits 12:8, the jump flag in bit 7 and the target in bits 6:0. uop1 and uop2 always show the fields of the line at uaddr, and code 0 means no operation.
- R3: Lines 0, 1 and 2 emit uop1 codes 1, 2 and 3 (memory address from PC, IR from memory, PC increment) and advance one line per clock.
- R4: Line 3 carries uop2 code 30 (dispatch), and the next uaddr is 4 plus ir_opcode.
- R5: Jump-table line 4+k moves to line 20+6k.
- R6: A line whose jump flag is clear, and which is not the dispatch line, is followed by the next line. Routines run on consecutive lines.
- R7: Every routine except halt returns to line 0 after its last line. The routine lengths in lines are 4, 3, 2, 3, 3, 1, 1 for opcodes 0 to 6, 1 for 9, 10 and 15, 5 for 11, 13 and 14, and 3 for 12.
- R8: Opcode 7 (halt) stays on line 62 for as long as reset is not applied, with uop1 and uop2 both 0.
- R9: Opcode 8 (skip) has uop2 code 31 on its first line, 68. The condition field selects the test: 00 means the accumulator is negative, 01 means zero, 10 means positive (neither negative nor zero), and 11 never holds. If the condition holds, control goes to line 70, which emits uop1 code 3. If it fails, control goes to line 69, which emits code 0. Either line is followed by line 0.
- R10: Routine uop1 sequences are 4,5,6 for opcode 1 (direct load), 4,5,7 for opcode 3 (add), 4,5,8 for opcode 4 (subtract), 4,5,15,5,7 for opcode 11 (indirect add), 11 for opcode 5, 14 for opcode 9 and 13 for opcode 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ir_opcode | input | 4 | Opcode field of the instruction register |
| ir_cond | input | 2 | Condition field of the instruction register, used by the skip routine |
| ac_neg | input | 1 | Accumulator is negative |
| ac_zero | input | 1 | Accumulator is zero |
| uop1 | output | 5 | First microoperation code of the current line |
| uop2 | output | 5 | Second microoperation code of the current line |
| uaddr | output | 7 | Current microaddress |

## Verification
Assertions check the following on every cycle:
- the fetch lines step by one;
- dispatch lands on 4 plus the opcode;
- each table entry lands on its slot;
- non-jump lines step by one;
- the skip line branches by the outcome of its condition;
- halt holds its line;
- the microaddress never leaves the used part of the store.

Only the bench's scenarios can show the following:
- the routine length for each opcode;
- the exact microoperation sequence inside each routine;
- the full truth table of condition code against accumulator state;
- the asynchronous reset taking effect mid-instruction;
- the two-cycle delay after reset is released.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UADDR_W     = 7;
  localparam int UOP_W       = 5;
  localparam int OPC_W       = 4;
  localparam int COND_W      = 2;
  localparam int FETCH_LINES = 4;
  localparam int TABLE_BASE  = FETCH_LINES;
  localparam int OPC_COUNT   = 2 ** OPC_W;
  localparam int SLOT_LINES  = 6;
  localparam int ROUT_BASE   = TABLE_BASE + OPC_COUNT;
  localparam int STORE_END   = ROUT_BASE + OPC_COUNT * SLOT_LINES;
  localparam int OPC_HALT    = 7;
  localparam int OPC_SKIP    = 8;

  typedef logic [UOP_W-1:0] uop_t;

  localparam uop_t U_NOP       = 5'd0;
  localparam uop_t U_MAR_PC    = 5'd1;
  localparam uop_t U_IR_MEM    = 5'd2;
  localparam uop_t U_PC_INC    = 5'd3;
  localparam uop_t U_MAR_IRX   = 5'd4;
  localparam uop_t U_MBR_MEM   = 5'd5;
  localparam uop_t U_AC_MBR    = 5'd6;
  localparam uop_t U_AC_ADD    = 5'd7;
  localparam uop_t U_AC_SUB    = 5'd8;
  localparam uop_t U_MBR_AC    = 5'd9;
  localparam uop_t U_MEM_MBR   = 5'd10;
  localparam uop_t U_AC_IN     = 5'd11;
  localparam uop_t U_OUT_AC    = 5'd12;
  localparam uop_t U_AC_CLR    = 5'd13;
  localparam uop_t U_PC_IRX    = 5'd14;
  localparam uop_t U_MAR_MBR   = 5'd15;
  localparam uop_t U_MBR_PC    = 5'd16;
  localparam uop_t U_PC_MBR    = 5'd17;
  localparam uop_t U_MBR_IRX   = 5'd18;
  localparam uop_t U_AC_INCMBR = 5'd19;
  localparam uop_t U_PC_AC     = 5'd20;
  localparam uop_t S_DISPATCH  = 5'd30;
  localparam uop_t S_COND      = 5'd31;

  typedef struct packed {
    uop_t               op1;
    uop_t               op2;
    logic               jmp;
    logic [UADDR_W-1:0] dest;
  } uword_t;

  function automatic uword_t mk_word(uop_t a, uop_t b, logic j, int d);
    uword_t w;
    w.op1  = a;
    w.op2  = b;
    w.jmp  = j;
    w.dest = UADDR_W'(d);
    return w;
  endfunction

  // Builds the control-store line at address a.
  function automatic uword_t rom_word(int a);
    uword_t w;
    uop_t   s1 [SLOT_LINES];
    uop_t   s2 [SLOT_LINES];
    int     n;
    int     op;
    int     ln;
    int     base;
    for (int i = 0; i < SLOT_LINES; i++) begin
      s1[i] = U_NOP;
      s2[i] = U_NOP;
    end
    n = 1;
    w = mk_word(U_NOP, U_NOP, 1'b1, 0);
    if (a < FETCH_LINES) begin
      case (a)
        0:       w = mk_word(U_MAR_PC, U_NOP, 1'b0, 0);
        1:       w = mk_word(U_IR_MEM, U_NOP, 1'b0, 0);
        2:       w = mk_word(U_PC_INC, U_NOP, 1'b0, 0);
        default: w = mk_word(U_NOP, S_DISPATCH, 1'b0, 0);
      endcase
    end else if (a < ROUT_BASE) begin
      w = mk_word(U_NOP, U_NOP, 1'b1, ROUT_BASE + SLOT_LINES * (a - TABLE_BASE));
    end else if (a < STORE_END) begin
      op   = (a - ROUT_BASE) / SLOT_LINES;
      ln   = (a - ROUT_BASE) % SLOT_LINES;
      base = a - ln;
      case (op)
        0: begin
          s1[0] = U_MBR_PC;    s2[0] = U_MAR_IRX;
          s1[1] = U_MEM_MBR;   s2[1] = U_MBR_IRX;
          s1[2] = U_AC_INCMBR; s1[3] = U_PC_AC;   n = 4;
        end
        1: begin s1[0] = U_MAR_IRX; s1[1] = U_MBR_MEM; s1[2] = U_AC_MBR; n = 3; end
        2: begin s1[0] = U_MAR_IRX; s2[0] = U_MBR_AC;  s1[1] = U_MEM_MBR; n = 2; end
        3: begin s1[0] = U_MAR_IRX; s1[1] = U_MBR_MEM; s1[2] = U_AC_ADD; n = 3; end
        4: begin s1[0] = U_MAR_IRX; s1[1] = U_MBR_MEM; s1[2] = U_AC_SUB; n = 3; end
        5:  s1[0] = U_AC_IN;
        6:  s1[0] = U_OUT_AC;
        9:  s1[0] = U_PC_IRX;
        10: s1[0] = U_AC_CLR;
        11: begin
          s1[0] = U_MAR_IRX; s1[1] = U_MBR_MEM; s1[2] = U_MAR_MBR;
          s1[3] = U_MBR_MEM; s1[4] = U_AC_ADD;  n = 5;
        end
        12: begin s1[0] = U_MAR_IRX; s1[1] = U_MBR_MEM; s1[2] = U_PC_MBR; n = 3; end
        13: begin
          s1[0] = U_MAR_IRX; s1[1] = U_MBR_MEM; s1[2] = U_MAR_MBR;
          s1[3] = U_MBR_MEM; s1[4] = U_AC_MBR;  n = 5;
        end
        14: begin
          s1[0] = U_MAR_IRX; s1[1] = U_MBR_MEM; s1[2] = U_MAR_MBR;
          s1[3] = U_MBR_AC;  s1[4] = U_MEM_MBR; n = 5;
        end
        default: n = 1;
      endcase
      if (op == OPC_HALT) begin
        w = (ln == 0) ? mk_word(U_NOP, U_NOP, 1'b1, a) : mk_word(U_NOP, U_NOP, 1'b1, 0);
      end else if (op == OPC_SKIP) begin
        case (ln)
          0:       w = mk_word(U_NOP, S_COND, 1'b1, base + 2);
          1:       w = mk_word(U_NOP, U_NOP, 1'b1, 0);
          2:       w = mk_word(U_PC_INC, U_NOP, 1'b1, 0);
          default: w = mk_word(U_NOP, U_NOP, 1'b1, 0);
        endcase
      end else if (ln < n) begin
        w = mk_word(s1[ln], s2[ln], (ln == n - 1), 0);
      end
    end
    return w;
  endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int AW = UADDR_W
) (
  input  logic [AW-1:0] addr,
  output uword_t        word
);
  localparam int DEPTH = 2 ** AW;

  uword_t tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_line
    assign tbl[g] = rom_word(g);
  end

  assign word = tbl[addr];
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int AW = UADDR_W,
  parameter int OW = OPC_W,
  parameter int CW = COND_W
) (
  input  logic [AW-1:0] addr,
  input  uword_t        word,
  input  logic [OW-1:0] opcode,
  input  logic [CW-1:0] cond,
  input  logic          ac_neg,
  input  logic          ac_zero,
  output logic [AW-1:0] nxt,
  output logic          cond_hit
);
  always_comb begin
    case (cond)
      2'b00:   cond_hit = ac_neg;
      2'b01:   cond_hit = ac_zero;
      2'b10:   cond_hit = !ac_neg && !ac_zero;
      default: cond_hit = 1'b0;
    endcase
  end

  always_comb begin
    if (word.op2 == S_DISPATCH) begin
      nxt = AW'(TABLE_BASE) + AW'(opcode);
    end else if (word.jmp && (word.op2 == S_COND)) begin
      nxt = cond_hit ? word.dest : addr + AW'(1);
    end else if (word.jmp) begin
      nxt = word.dest;
    end else begin
      nxt = addr + AW'(1);
    end
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OPC_W-1:0]   ir_opcode,
  input  logic [COND_W-1:0]  ir_cond,
  input  logic               ac_neg,
  input  logic               ac_zero,
  output logic [UOP_W-1:0]   uop1,
  output logic [UOP_W-1:0]   uop2,
  output logic [UADDR_W-1:0] uaddr
);
  localparam int HALT_LINE = ROUT_BASE + SLOT_LINES * OPC_HALT;

  logic [1:0]         rst_pipe;
  logic               rst_ok;
  logic [UADDR_W-1:0] upc_q;
  logic [UADDR_W-1:0] upc_d;
  uword_t             cur;
  logic               hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  useq_store #(.AW(UADDR_W)) u_store (
    .addr (upc_q),
    .word (cur)
  );

  useq_next #(.AW(UADDR_W), .OW(OPC_W), .CW(COND_W)) u_next (
    .addr     (upc_q),
    .word     (cur),
    .opcode   (ir_opcode),
    .cond     (ir_cond),
    .ac_neg   (ac_neg),
    .ac_zero  (ac_zero),
    .nxt      (upc_d),
    .cond_hit (hit)
  );

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) upc_q <= '0;
    else         upc_q <= upc_d;
  end

  assign uaddr = upc_q;
  assign uop1  = cur.op1;
  assign uop2  = cur.op2;

  // R3
  fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (uaddr < UADDR_W'(FETCH_LINES - 1)) |=> (uaddr == $past(uaddr) + UADDR_W'(1)));

  // R4
  dispatch_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (uaddr == UADDR_W'(FETCH_LINES - 1)) |=>
      (uaddr == UADDR_W'(TABLE_BASE) + UADDR_W'($past(ir_opcode))));

  // R5
  table_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (uaddr >= UADDR_W'(TABLE_BASE) && uaddr < UADDR_W'(ROUT_BASE)) |=>
      (uaddr >= UADDR_W'(ROUT_BASE) &&
       ((uaddr - UADDR_W'(ROUT_BASE)) % UADDR_W'(SLOT_LINES)) == '0));

  // R6
  no_jump_step_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!cur.jmp && cur.op2 != S_DISPATCH) |=> (uaddr == $past(uaddr) + UADDR_W'(1)));

  // R9
  skip_fail_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (cur.jmp && cur.op2 == S_COND && !hit) |=> (uaddr == $past(uaddr) + UADDR_W'(1)));

  // R9
  skip_take_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (cur.jmp && cur.op2 == S_COND && hit) |=> (uop1 == U_PC_INC));

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (uaddr == UADDR_W'(HALT_LINE)) |=> $stable(uaddr));

  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    uaddr < UADDR_W'(STORE_END));
endmodule

// File: tb/sim_useq_ctrl.sv
`timescale 1ns/1ps
module sim_useq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] opc;
  logic [1:0] cnd;
  logic       neg;
  logic       zro;
  logic [4:0] u1;
  logic [4:0] u2;
  logic [6:0] ua;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  useq_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .ir_opcode (opc),
    .ir_cond   (cnd),
    .ac_neg    (neg),
    .ac_zero   (zro),
    .uop1      (u1),
    .uop2      (u2),
    .uaddr     (ua)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int rlen(int op);
    case (op)
      0: return 4;
      1, 3, 4, 12: return 3;
      2: return 2;
      11, 13, 14: return 5;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_op1(int op, int i);
    case (op)
      1: return (i == 0) ? 4 : (i == 1) ? 5 : 6;
      3: return (i == 0) ? 4 : (i == 1) ? 5 : 7;
      4: return (i == 0) ? 4 : (i == 1) ? 5 : 8;
      11: case (i) 0: return 4; 1: return 5; 2: return 15; 3: return 5; default: return 7; endcase
      5: return 11;
      9: return 14;
      10: return 13;
      default: return -1;
    endcase
  endfunction

  // Starts at a falling edge with uaddr at 0.
  task automatic run_instr(int op, int c, int acs);
    int base;
    int e;
    bit hit;
    opc = 4'(op);
    cnd = 2'(c);
    neg = (acs == 0);
    zro = (acs == 1);
    base = 20 + 6 * op;
    chk("R3", "fetch line0 addr", int'(ua), 0);
    chk("R3", "fetch line0 uop1", int'(u1), 1);
    chk("R2", "fetch line0 uop2 nop", int'(u2), 0);
    step();
    chk("R3", "fetch line1 addr", int'(ua), 1);
    chk("R3", "fetch line1 uop1", int'(u1), 2);
    step();
    chk("R3", "fetch line2 addr", int'(ua), 2);
    chk("R3", "fetch line2 uop1", int'(u1), 3);
    step();
    chk("R4", "dispatch addr", int'(ua), 3);
    chk("R4", "dispatch uop2", int'(u2), 30);
    step();
    chk("R4", "table entry", int'(ua), 4 + op);
    step();
    chk("R5", "routine start", int'(ua), base);
    if (op == 7) begin
      for (int k = 0; k < 20; k++) begin
        step();
        chk("R8", "halt line", int'(ua), base);
        chk("R8", "halt uop1", int'(u1), 0);
        chk("R8", "halt uop2", int'(u2), 0);
      end
    end else if (op == 8) begin
      chk("R9", "cond uop2", int'(u2), 31);
      hit = (c == 0 && acs == 0) || (c == 1 && acs == 1) || (c == 2 && acs == 2);
      step();
      chk("R9", "skip branch", int'(ua), hit ? base + 2 : base + 1);
      chk("R9", "skip uop1", int'(u1), hit ? 3 : 0);
      step();
      chk("R7", "return to fetch", int'(ua), 0);
    end else begin
      for (int i = 0; i < rlen(op); i++) begin
        if (i > 0) begin
          step();
          chk("R6", "routine line", int'(ua), base + i);
        end
        e = exp_op1(op, i);
        if (e >= 0) chk("R10", "routine uop1", int'(u1), e);
      end
      step();
      chk("R7", "return to fetch", int'(ua), 0);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    opc = '0;
    cnd = '0;
    neg = 1'b0;
    zro = 1'b0;
    repeat (3) step();
    chk("R1", "reset addr", int'(ua), 0);
    chk("R1", "reset uop1", int'(u1), 1);
    chk("R1", "reset uop2", int'(u2), 0);
    rst_n = 1'b1;
    step();
    chk("R1", "release delay 1", int'(ua), 0);
    step();
    chk("R1", "release delay 2", int'(ua), 0);

    for (int op = 0; op < 16; op++) begin
      if (op != 7 && op != 8) run_instr(op, 0, 2);
    end
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 3; s++) run_instr(8, c, s);
    end

    run_instr(7, 0, 2);
    rst_n = 1'b0;
    #1;
    chk("R1", "async reset from halt", int'(ua), 0);
    step();
    rst_n = 1'b1;
    step();
    step();
    run_instr(3, 0, 2);

    // Reset in the middle of a routine.
    opc = 4'd11;
    repeat (7) step();
    rst_n = 1'b0;
    #1;
    chk("R1", "async reset mid routine", int'(ua), 0);
    chk("R1", "async reset uop1", int'(u1), 1);
    step();
    rst_n = 1'b1;
    step();
    step();
    run_instr(1, 0, 2);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule